// File: doc/BRIEF.md
# Memory-Type Range Configuration Register File

This block stores the cache memory-type configuration of a single processor. It holds a default-type register, a page-attribute register, eleven fixed-range registers and `NVAR` pairs of variable-range base and mask registers. Software reaches them through a plain register port with a 12-bit address, 64-bit write data, and write and read strobes. A read-only capability register is generated on the fly and is not stored.

Every write is checked against the rule for its register class before it is stored. A write that breaks the rule, a write to the capability register, and any access to an unmapped address are all refused. A refused access raises a one-cycle error pulse and changes no state. Stored state is also driven out in parallel, so a lookup block can resolve memory types without going through the port.

Top module: `mtrr_regfile`

## Requirements
- R1: After reset every stored register reads zero, so the global enable (default-type bit 11) is off; `err` and `rdata` are 0.
- R2: Addresses 0x200 to 0x200+2*NVAR-1 hold the variable pairs: an even address is the base of pair (addr-0x200)/2 and an odd address is its mask. A read of any mapped address returns the stored value on `rdata` one cycle after `rd_en`, and `rdata` is 0 in cycles that follow no mapped read.
- R3: Address 0x277 is the page-attribute register. A write is stored only if each of its eight bytes holds 0, 1, 4, 5, 6 or 7.
- R4: Fixed-range registers sit at 0x250, 0x258-0x259 and 0x268-0x26F. A write is stored only if each of its eight bytes is a legal range type: 0, 1, 4, 5 or 6.
- R5: Address 0x2FF is the default-type register. A write is stored only if no bit other than 11, 10 and 7:0 is set and bits 7:0 are a legal range type.
- R6: A variable base write is stored only if bits 11:8 are zero, no bit at or above `PA_W` is set, and bits 7:0 are a legal range type.
- R7: A variable mask write is stored only if bits 10:0 are zero and no bit at or above `PA_W` is set.
- R8: A read of 0xFE returns 0x500 OR NVAR; a write to 0xFE is refused.
- R9: A read or write of any other address is refused; a refused read returns 0 on `rdata`.
- R10: A refused access drives `err` high for exactly the cycle after the strobe and leaves every stored register unchanged; an accepted access leaves `err` low.
- R11: `fix_types_o` is an array of 88 type bytes, byte k in bits 8k+7:8k. The 0x250 register fills bytes 0-7, 0x258+u fills bytes 8+8u to 15+8u, and 0x268+u fills bytes 24+8u to 31+8u, register byte j to array byte base+j.
- R12: The parallel outputs `def_type_o`, `pat_o`, `fix_types_o`, `var_base_o` (pair i in bits 64i+63:64i) and `var_mask_o` show an accepted write from the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 12 | Register address |
| wdata | input | 64 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 64 | Read data, valid the cycle after `rd_en` |
| err | output | 1 | One-cycle pulse for a refused access |
| def_type_o | output | 64 | Stored default-type register |
| pat_o | output | 64 | Stored page-attribute register |
| fix_types_o | output | 704 | 88 fixed-range type bytes |
| var_base_o | output | NVAR*64 | Variable base registers, pair i at 64i |
| var_mask_o | output | NVAR*64 | Variable mask registers, pair i at 64i |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. Under that rule an error pulse comes from a single refused access, so it can be tied to unchanged state. The stimulus issues each write or read as a separate one-cycle strobe with at least one idle cycle after it, so this assumption always holds. It sweeps type codes over every byte lane and single set bits over every bit position of each register class.

// File: rtl/mtrr_regfile.sv
module mtrr_regfile #(
  parameter int NVAR = 8,
  parameter int PA_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [11:0]       addr,
  input  logic [63:0]       wdata,
  input  logic              wr_en,
  input  logic              rd_en,
  output logic [63:0]       rdata,
  output logic              err,
  output logic [63:0]       def_type_o,
  output logic [63:0]       pat_o,
  output logic [703:0]      fix_types_o,
  output logic [NVAR*64-1:0] var_base_o,
  output logic [NVAR*64-1:0] var_mask_o
);

  localparam int          NFIX    = 11;
  localparam int          VI_W    = $clog2(2*NVAR);
  localparam logic [11:0] VAR_LO  = 12'h200;
  localparam logic [11:0] VAR_HI  = 12'(32'h200 + 2*NVAR - 1);
  localparam logic [11:0] PAT_A   = 12'h277;
  localparam logic [11:0] DEF_A   = 12'h2FF;
  localparam logic [11:0] CAP_A   = 12'h0FE;
  localparam logic [63:0] CAP_VAL = 64'h500 | 64'(NVAR);
  localparam logic [63:0] HI_MASK = ~((64'd1 << PA_W) - 64'd1);
  localparam logic [63:0] DEF_OK  = 64'hCFF;

  function automatic logic range_ok(input logic [7:0] t);
    return (t == 8'd0) || (t == 8'd1) || (t == 8'd4) || (t == 8'd5) || (t == 8'd6);
  endfunction

  function automatic logic all_range_ok(input logic [63:0] d);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < 8; b++) ok = ok & range_ok(d[b*8 +: 8]);
    return ok;
  endfunction

  function automatic logic all_pat_ok(input logic [63:0] d);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < 8; b++) ok = ok & (range_ok(d[b*8 +: 8]) || d[b*8 +: 8] == 8'd7);
    return ok;
  endfunction

  logic [63:0] var_q [2*NVAR];
  logic [63:0] fix_q [NFIX];
  logic [63:0] pat_q, def_q;

  logic [11:0]     var_off;
  logic [VI_W-1:0] vidx;
  logic [3:0]      fix_slot;
  logic            is_var, is_fix, is_pat, is_def, is_cap, rd_hit, wr_ok, hi_clear;
  logic [63:0]     rd_val;

  assign var_off  = addr - VAR_LO;
  assign vidx     = var_off[VI_W-1:0];
  assign is_var   = (addr >= VAR_LO) && (addr <= VAR_HI);
  assign is_pat   = addr == PAT_A;
  assign is_def   = addr == DEF_A;
  assign is_cap   = addr == CAP_A;
  assign rd_hit   = is_var | is_fix | is_pat | is_def | is_cap;
  assign hi_clear = (wdata & HI_MASK) == 64'd0;

  always_comb begin
    is_fix   = 1'b1;
    fix_slot = 4'd0;
    if (addr == 12'h250)            fix_slot = 4'd0;
    else if (addr[11:1] == 11'h12C) fix_slot = 4'd1 + {3'd0, addr[0]};
    else if (addr[11:3] == 9'h04D)  fix_slot = 4'd3 + {1'b0, addr[2:0]};
    else                            is_fix = 1'b0;
  end

  always_comb begin
    wr_ok = 1'b0;
    if (is_var) begin
      if (var_off[0]) wr_ok = hi_clear && (wdata[10:0] == 11'd0);
      else            wr_ok = hi_clear && (wdata[11:8] == 4'd0) && range_ok(wdata[7:0]);
    end
    else if (is_fix) wr_ok = all_range_ok(wdata);
    else if (is_pat) wr_ok = all_pat_ok(wdata);
    else if (is_def) wr_ok = ((wdata & ~DEF_OK) == 64'd0) && range_ok(wdata[7:0]);
  end

  always_comb begin
    rd_val = 64'd0;
    if (is_var)      rd_val = var_q[vidx];
    else if (is_fix) rd_val = fix_q[fix_slot];
    else if (is_pat) rd_val = pat_q;
    else if (is_def) rd_val = def_q;
    else if (is_cap) rd_val = CAP_VAL;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2*NVAR; i++) var_q[i] <= 64'd0;
      for (int i = 0; i < NFIX; i++) fix_q[i] <= 64'd0;
      pat_q <= 64'd0;
      def_q <= 64'd0;
      err   <= 1'b0;
      rdata <= 64'd0;
    end else begin
      err   <= (wr_en && !wr_ok) || (rd_en && !rd_hit);
      rdata <= (rd_en && rd_hit) ? rd_val : 64'd0;
      if (wr_en && wr_ok) begin
        if (is_var)      var_q[vidx]     <= wdata;
        else if (is_fix) fix_q[fix_slot] <= wdata;
        else if (is_pat) pat_q           <= wdata;
        else if (is_def) def_q           <= wdata;
      end
    end
  end

  assign pat_o      = pat_q;
  assign def_type_o = def_q;

  for (genvar s = 0; s < NFIX; s++) begin : g_fix
    assign fix_types_o[s*64 +: 64] = fix_q[s];
  end

  for (genvar p = 0; p < NVAR; p++) begin : g_var
    assign var_base_o[p*64 +: 64] = var_q[2*p];
    assign var_mask_o[p*64 +: 64] = var_q[2*p+1];
    // R6
    base_hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (var_q[2*p][63:PA_W] == '0) && (var_q[2*p][11:8] == 4'd0));
    // R7
    mask_lo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (var_q[2*p+1][10:0] == 11'd0) && (var_q[2*p+1][63:PA_W] == '0));
  end

  // R10
  err_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> ($stable(pat_o) && $stable(def_type_o) && $stable(fix_types_o)
             && $stable(var_base_o) && $stable(var_mask_o)));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !rd_en) |=> (!err && rdata == 64'd0));

  // R8
  cap_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !wr_en && addr == CAP_A) |=> (rdata == CAP_VAL && !err));

  // R8
  cap_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == CAP_A) |=> err);

  // R5
  def_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((def_type_o & ~DEF_OK) == 64'd0) && range_ok(def_type_o[7:0]));

  // R3
  pat_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_pat_ok(pat_o));

endmodule

// File: tb/mtrr_regfile_tb_top.sv
module mtrr_regfile_tb_top;
  localparam int CLK_PER = 10;
  localparam int N  = 8;
  localparam int PA = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [63:0] wdata = '0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [63:0] rdata, def_type_o, pat_o;
  logic err;
  logic [703:0] fix_types_o;
  logic [N*64-1:0] var_base_o, var_mask_o;

  mtrr_regfile #(.NVAR(N), .PA_W(PA)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .err(err), .def_type_o(def_type_o), .pat_o(pat_o),
    .fix_types_o(fix_types_o), .var_base_o(var_base_o), .var_mask_o(var_mask_o));

  always #(CLK_PER/2) clk = ~clk;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  logic [63:0] m_var [2*N];
  logic [63:0] m_fix [11];
  logic [63:0] m_pat, m_def;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit rt(input logic [7:0] t);
    return t inside {8'd0, 8'd1, 8'd4, 8'd5, 8'd6};
  endfunction

  function automatic int fix_slot(input logic [11:0] a);
    if (a == 12'h250) return 0;
    if (a == 12'h258 || a == 12'h259) return 1 + int'(a - 12'h258);
    if (a >= 12'h268 && a <= 12'h26F) return 3 + int'(a - 12'h268);
    return -1;
  endfunction

  function automatic logic [11:0] fix_addr(input int s);
    if (s == 0) return 12'h250;
    if (s < 3) return 12'(12'h258 + s - 1);
    return 12'(12'h268 + s - 3);
  endfunction

  function automatic bit is_var(input logic [11:0] a);
    return a >= 12'h200 && a < 12'(12'h200 + 2*N);
  endfunction

  function automatic bit wr_ok(input logic [11:0] a, input logic [63:0] d);
    bit ok;
    logic [63:0] hi;
    hi = ~((64'd1 << PA) - 64'd1);
    if (is_var(a)) begin
      if (a[0]) return (d & hi) == 0 && d[10:0] == 0;
      return (d & hi) == 0 && d[11:8] == 0 && rt(d[7:0]);
    end
    if (fix_slot(a) >= 0) begin
      ok = 1;
      for (int b = 0; b < 8; b++) ok &= rt(d[8*b +: 8]);
      return ok;
    end
    if (a == 12'h277) begin
      ok = 1;
      for (int b = 0; b < 8; b++) ok &= (rt(d[8*b +: 8]) || d[8*b +: 8] == 8'd7);
      return ok;
    end
    if (a == 12'h2FF) return (d & ~64'hCFF) == 0 && rt(d[7:0]);
    return 0;
  endfunction

  function automatic bit rd_hit(input logic [11:0] a);
    return is_var(a) || fix_slot(a) >= 0 || a == 12'h277 || a == 12'h2FF || a == 12'h0FE;
  endfunction

  function automatic logic [63:0] exp_rd(input logic [11:0] a);
    if (is_var(a)) return m_var[int'(a - 12'h200)];
    if (fix_slot(a) >= 0) return m_fix[fix_slot(a)];
    if (a == 12'h277) return m_pat;
    if (a == 12'h2FF) return m_def;
    if (a == 12'h0FE) return 64'h500 + 64'(N);
    return 64'd0;
  endfunction

  task automatic cmp_state(input string req);
    bit ok;
    ok = 1;
    for (int s = 0; s < 11; s++) ok &= fix_types_o[64*s +: 64] === m_fix[s];
    chk(ok, {req, " fixed out"}, fix_types_o[63:0], m_fix[0]);
    chk(pat_o === m_pat, {req, " pat out"}, pat_o, m_pat);
    chk(def_type_o === m_def, {req, " def out"}, def_type_o, m_def);
    ok = 1;
    for (int p = 0; p < N; p++) begin
      ok &= var_base_o[64*p +: 64] === m_var[2*p];
      ok &= var_mask_o[64*p +: 64] === m_var[2*p+1];
    end
    chk(ok, {req, " var out"}, var_base_o[63:0], m_var[0]);
  endtask

  task automatic do_wr(input logic [11:0] a, input logic [63:0] d, input string req);
    bit ok;
    int s;
    ok = wr_ok(a, d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    chk(err === !ok, {req, " R10 err"}, 64'(err), 64'(!ok));
    if (ok) begin
      s = fix_slot(a);
      if (is_var(a)) m_var[int'(a - 12'h200)] = d;
      else if (s >= 0) m_fix[s] = d;
      else if (a == 12'h277) m_pat = d;
      else if (a == 12'h2FF) m_def = d;
    end
    cmp_state({req, " R12"});
  endtask

  task automatic do_rd(input logic [11:0] a, input string req);
    logic [63:0] e;
    e = exp_rd(a);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    chk(err === !rd_hit(a), {req, " R10 rd err"}, 64'(err), 64'(!rd_hit(a)));
    chk(rdata === e, {req, " R2 rdata"}, rdata, e);
    @(negedge clk);
    chk(rdata === 64'd0 && err === 1'b0, {req, " R2 idle"}, rdata, 64'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    logic [7:0] code;
    logic [11:0] bad [14];
    for (int i = 0; i < 2*N; i++) m_var[i] = '0;
    for (int i = 0; i < 11; i++) m_fix[i] = '0;
    m_pat = '0; m_def = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(err === 1'b0 && rdata === 64'd0, "R1 reset outputs", rdata, 64'd0);
    chk(def_type_o[11] === 1'b0, "R1 global enable off", def_type_o, 64'd0);
    cmp_state("R1 reset");
    for (int i = 0; i < 2*N; i++) do_rd(12'(12'h200 + i), "R1 var reset");
    for (int s = 0; s < 11; s++) do_rd(fix_addr(s), "R1 fix reset");
    do_rd(12'h277, "R1 pat reset");
    do_rd(12'h2FF, "R1 def reset");

    // R3 page attribute sweep
    for (int b = 0; b < 8; b++)
      for (int c = 0; c < 11; c++) begin
        code = (c == 10) ? 8'hFF : 8'(c);
        d = {8{8'h06}};
        d[8*b +: 8] = code;
        do_wr(12'h277, d, "R3 pat byte");
        do_rd(12'h277, "R3 pat readback");
      end

    // R4 / R11 fixed range sweep
    for (int s = 0; s < 11; s++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 11; c++) begin
          code = (c == 10) ? 8'hFF : 8'(c);
          d = {8{8'(s % 2 == 0 ? 8'h05 : 8'h01)}};
          d[8*b +: 8] = code;
          do_wr(fix_addr(s), d, "R4 fix byte");
          chk(fix_types_o[(8*s + b)*8 +: 8] === m_fix[s][8*b +: 8], "R11 byte map",
              64'(fix_types_o[(8*s + b)*8 +: 8]), 64'(m_fix[s][8*b +: 8]));
        end
    for (int s = 0; s < 11; s++) do_rd(fix_addr(s), "R4 fix readback");

    // R5 default type
    for (int bt = 8; bt < 64; bt++) do_wr(12'h2FF, (64'd1 << bt) | 64'd6, "R5 def bit");
    for (int c = 0; c < 11; c++) do_wr(12'h2FF, 64'hC00 | 64'(c == 10 ? 255 : c), "R5 def type");
    do_rd(12'h2FF, "R5 def readback");

    // R6 / R7 variable pairs
    for (int p = 0; p < N; p++) begin
      do_wr(12'(12'h200 + 2*p), 64'(p + 1) << 20 | 64'd6, "R6 base pair");
      do_wr(12'(12'h201 + 2*p), (64'(p + 3) << 24) | 64'h800, "R7 mask pair");
    end
    for (int i = 0; i < 2*N; i++) do_rd(12'(12'h200 + i), "R2 var readback");
    for (int bt = 0; bt < 64; bt++) do_wr(12'h204, (64'd1 << bt) | 64'd1, "R6 base bit");
    for (int c = 0; c < 11; c++) do_wr(12'h206, 64'h1000 | 64'(c == 10 ? 255 : c), "R6 base type");
    for (int bt = 0; bt < 64; bt++) do_wr(12'h207, 64'd1 << bt, "R7 mask bit");
    do_rd(12'h204, "R6 base readback");
    do_rd(12'h207, "R7 mask readback");

    // R8 capability
    do_rd(12'h0FE, "R8 cap read");
    do_wr(12'h0FE, 64'd0, "R8 cap write");
    do_rd(12'h0FE, "R8 cap read after write");

    // R9 unmapped addresses
    bad = '{12'h000, 12'h1FF, 12'(12'h200 + 2*N), 12'h24F, 12'h251, 12'h257, 12'h25A,
            12'h267, 12'h270, 12'h276, 12'h278, 12'h2FE, 12'h0FF, 12'h0FD};
    foreach (bad[i]) begin
      do_rd(bad[i], "R9 unmapped read");
      do_wr(bad[i], 64'd0, "R9 unmapped write");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule